// File: doc/BRIEF.md
# Shared-Pipeline Concurrent Computation Unit

This block lets a number of logical operation slots share one physical pipelined execution unit. Each slot owns an operand latch and a result latch that belongs to it alone. Outside logic that tracks dependencies hands an operation to a free slot. The slot holds its operands until a round-robin arbiter selects it. The operands then go onto the single execution port together with the slot index. That index travels through a tag pipeline whose depth matches the execution latency. When the result comes back, it is steered into the result latch of the slot that issued it.

Because every slot keeps its own operation from acceptance until its result is read, a whole batch of operations can be in flight at once. The outside logic sees each slot as a separate functional unit. It watches a per-slot ready flag and a per-slot done flag, and it frees a slot by pulsing that slot's read strobe. The arithmetic itself sits outside the block, on the execution port. The block expects the result of an operation presented in cycle t on its result input exactly `LAT` cycles later. It never stalls that port: a slot cannot be handed new work until its previous result has been read, so the destination latch is always free when a result arrives.

Top module: `sp_unit`

## Requirements
- R1: After reset every slot reports ready (all `req_ready` bits 1), no slot reports done (all `done` bits 0), and `ex_valid` is 0.
- R2: A slot accepts an operation on a clock edge where its `req_valid` and `req_ready` bits are both 1. From the next cycle, its `req_ready` stays 0 until its result has been read.
- R3: `ex_valid` is 1 in exactly the cycles in which at least one slot holds accepted operands that have not yet been sent. Exactly one such slot is sent per cycle.
- R4: The slot that is sent is chosen round-robin. The search starts at the index one above the slot sent most recently and wraps from N-1 to 0. After reset the search starts at slot 0.
- R5: While `ex_valid` is 1, `ex_a` and `ex_b` carry the two operands that the chosen slot latched when it accepted its operation.
- R6: An operation sent in the cycle after its acceptance edge E raises the `done` bit of its own slot in the cycle after edge E+1+LAT. That slot's `res_data` field (bits i*DW+DW-1 down to i*DW) then holds the value that was present on `ex_res` LAT cycles after the operation was sent.
- R7: A slot's `done` bit and `res_data` field stay unchanged for as long as its `res_read` bit is 0.
- R8: A `res_read` bit of 1 on an edge where that slot is done clears `done` and sets `req_ready` in the next cycle. A `res_read` bit of 1 at any other time has no effect.
- R9: A `req_valid` bit of 1 while that slot is not ready is ignored. The slot's latched operands, and so its result, are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | N | Per-slot offer of a new operation |
| req_a | input | N*DW | Per-slot first operand, slot i in bits i*DW+DW-1:i*DW |
| req_b | input | N*DW | Per-slot second operand, same packing |
| req_ready | output | N | Per-slot free flag |
| done | output | N | Per-slot result-available flag |
| res_data | output | N*DW | Per-slot result latch contents, same packing |
| res_read | input | N | Per-slot strobe that consumes the result |
| ex_valid | output | 1 | An operation is being sent to the execution unit this cycle |
| ex_a | output | DW | First operand sent to the execution unit |
| ex_b | output | DW | Second operand sent to the execution unit |
| ex_res | input | DW | Execution-unit result, due LAT cycles after its operands |

## Verification
An operation accepted at edge E is sent in the cycle that follows E. Its result is taken into the slot at edge E+1+LAT, so `done` is first seen high one cycle after that edge. A freed slot shows ready one cycle after the read edge. The bench holds a behavioural model that advances at each rising edge from the inputs driven in the cycle before it. The model keeps a queue of outstanding results, each stamped with the edge at which it is due. At every falling edge, the model's predicted ready, done, result and execution-port values are compared with the outputs. Directed checks count edges from the acceptance edge and sample `done` exactly LAT and LAT+1 edges later. They also check which slot's operands appear on the execution port in the first two cycles after a burst accepted by all slots at once.

// File: rtl/sp_pkg.sv
// Package: shared types of the shared-pipeline computation unit.
// Assumes nothing beyond SystemVerilog 2017.
package sp_pkg;

    // Life cycle of one slot: free, waiting to be sent, in the pipeline, result held.
    typedef enum logic [1:0] {
        SLOT_FREE   = 2'd0,
        SLOT_WAIT   = 2'd1,
        SLOT_FLIGHT = 2'd2,
        SLOT_HELD   = 2'd3
    } slot_state_e;

endpackage

// File: rtl/sp_slot.sv
// One operation slot: operand latch, result latch and its life-cycle state.
// Assumes grant_i is only given while pend_o is high and wr_en_i only while
// the slot is in flight; the top guarantees both.
module sp_slot #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          grant_i,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          rd_i,
    output logic          ready_o,
    output logic          pend_o,
    output logic          done_o,
    output logic [DW-1:0] opa_o,
    output logic [DW-1:0] opb_o,
    output logic [DW-1:0] res_o
);
    import sp_pkg::*;

    slot_state_e state_q;
    logic [DW-1:0] opa_q, opb_q, res_q;

    // Advance the slot state on accept, send, write-back and read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_FREE;
        end else begin
            case (state_q)
                SLOT_FREE:   if (acc_i)   state_q <= SLOT_WAIT;
                SLOT_WAIT:   if (grant_i) state_q <= SLOT_FLIGHT;
                SLOT_FLIGHT: if (wr_en_i) state_q <= SLOT_HELD;
                SLOT_HELD:   if (rd_i)    state_q <= SLOT_FREE;
                default:                  state_q <= SLOT_FREE;
            endcase
        end
    end

    // Capture operands only when the slot is free and an operation is offered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opa_q <= '0;
            opb_q <= '0;
        end else if (state_q == SLOT_FREE && acc_i) begin
            opa_q <= a_i;
            opb_q <= b_i;
        end
    end

    // Capture the routed result when this slot's tag leaves the pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (state_q == SLOT_FLIGHT && wr_en_i) begin
            res_q <= wr_data_i;
        end
    end

    // Decode the state into the slot's flags.
    always_comb begin
        ready_o = (state_q == SLOT_FREE);
        pend_o  = (state_q == SLOT_WAIT);
        done_o  = (state_q == SLOT_HELD);
    end

    assign opa_o = opa_q;
    assign opb_o = opb_q;
    assign res_o = res_q;

endmodule

// File: rtl/sp_rr_arb.sv
// Round-robin arbiter: grants one requester per cycle, searching upward from
// the index after the previous winner. Assumes N >= 2.
module sp_rr_arb #(
    parameter int N  = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  grant_o,
    output logic [IW-1:0] gidx_o,
    output logic          any_o
);
    logic [IW-1:0] last_q;

    // Pick the first requester after the last winner, wrapping around.
    always_comb begin
        grant_o = '0;
        gidx_o  = '0;
        any_o   = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (int'(last_q) + k) % N;
            if (!any_o && req_i[idx]) begin
                any_o        = 1'b1;
                grant_o[idx] = 1'b1;
                gidx_o       = IW'(idx);
            end
        end
    end

    // Remember the winner; reset points at N-1 so slot 0 is searched first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= IW'(N - 1);
        end else if (any_o) begin
            last_q <= gidx_o;
        end
    end

endmodule

// File: rtl/sp_tag_pipe.sv
// Tag pipeline: carries a valid bit and a slot index through LAT stages,
// aligned with the external execution unit's fixed latency. Assumes LAT >= 1.
module sp_tag_pipe #(
    parameter int LAT = 3,
    parameter int IW  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vld_i,
    input  logic [IW-1:0] tag_i,
    output logic          vld_o,
    output logic [IW-1:0] tag_o
);
    logic [LAT-1:0] vld_q;
    logic [IW-1:0]  tag_q [LAT];

    // First stage takes the tag of the operation sent this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q[0] <= 1'b0;
            tag_q[0] <= '0;
        end else begin
            vld_q[0] <= vld_i;
            tag_q[0] <= tag_i;
        end
    end

    for (genvar s = 1; s < LAT; s++) begin : g_stage
        // Each later stage shifts the tag one step toward the exit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[s] <= 1'b0;
                tag_q[s] <= '0;
            end else begin
                vld_q[s] <= vld_q[s-1];
                tag_q[s] <= tag_q[s-1];
            end
        end
    end

    assign vld_o = vld_q[LAT-1];
    assign tag_o = tag_q[LAT-1];

endmodule

// File: rtl/sp_unit.sv
// Shared-pipeline computation unit top. N slots share one execution port;
// a round-robin funnel sends one waiting slot per cycle and a tag pipeline
// routes each result back to its slot. Assumes the execution unit returns
// the result of the operands shown in cycle t on ex_res in cycle t+LAT and
// never stalls.
module sp_unit #(
    parameter int N   = 4,
    parameter int DW  = 16,
    parameter int LAT = 3,
    localparam int IW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req_valid,
    input  logic [N*DW-1:0] req_a,
    input  logic [N*DW-1:0] req_b,
    output logic [N-1:0]    req_ready,
    output logic [N-1:0]    done,
    output logic [N*DW-1:0] res_data,
    input  logic [N-1:0]    res_read,
    output logic            ex_valid,
    output logic [DW-1:0]   ex_a,
    output logic [DW-1:0]   ex_b,
    input  logic [DW-1:0]   ex_res
);
    logic [N-1:0]  pend;
    logic [N-1:0]  grant;
    logic [N-1:0]  wr_en;
    logic [IW-1:0] gidx;
    logic          any_grant;
    logic          tp_vld;
    logic [IW-1:0] tp_tag;
    logic [DW-1:0] opa [N];
    logic [DW-1:0] opb [N];

    for (genvar i = 0; i < N; i++) begin : g_slot
        sp_slot #(.DW(DW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .acc_i     (req_valid[i]),
            .a_i       (req_a[i*DW +: DW]),
            .b_i       (req_b[i*DW +: DW]),
            .grant_i   (grant[i]),
            .wr_en_i   (wr_en[i]),
            .wr_data_i (ex_res),
            .rd_i      (res_read[i]),
            .ready_o   (req_ready[i]),
            .pend_o    (pend[i]),
            .done_o    (done[i]),
            .opa_o     (opa[i]),
            .opb_o     (opb[i]),
            .res_o     (res_data[i*DW +: DW])
        );
    end

    sp_rr_arb #(.N(N)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (pend),
        .grant_o (grant),
        .gidx_o  (gidx),
        .any_o   (any_grant)
    );

    sp_tag_pipe #(.LAT(LAT), .IW(IW)) u_tags (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (any_grant),
        .tag_i (gidx),
        .vld_o (tp_vld),
        .tag_o (tp_tag)
    );

    // Fan-in: put the granted slot's operands on the execution port.
    always_comb begin
        ex_valid = any_grant;
        ex_a     = opa[gidx];
        ex_b     = opb[gidx];
    end

    // Fan-out: enable the result latch named by the tag leaving the pipeline.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            wr_en[i] = tp_vld && (tp_tag == IW'(i));
        end
    end

endmodule

// File: rtl/sp_unit_chk.sv
// Checker for sp_unit: protocol properties on slot flags, grants and routing.
// Attached to every sp_unit instance by the bind statement below.
module sp_unit_chk #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  req_ready,
    input logic [N-1:0]  done,
    input logic [N-1:0]  res_read,
    input logic [N-1:0]  grant,
    input logic          ex_valid,
    input logic          tp_vld,
    input logic [IW-1:0] tp_tag
);
    // R3: at most one slot is sent per cycle, and only when ex_valid is high.
    a_r3_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant != '0) == ex_valid));

    // R2: a slot holding a result never reports ready.
    a_r2_busy_while_held: assert property (@(posedge clk) disable iff (!rst_n)
        (done & req_ready) == '0);

    // R7: a held result stays held until it is read.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(done) & ~$past(res_read)) & ~done) == '0);

    // R8: a read of a held result frees the slot on the next cycle.
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(done & res_read) & (done | ~req_ready)) == '0);

    // R6: a returning result only targets a busy slot that holds no result.
    a_r6_route_free: assert property (@(posedge clk) disable iff (!rst_n)
        tp_vld |-> (!done[tp_tag] && !req_ready[tp_tag]));

endmodule

bind sp_unit sp_unit_chk #(.N(N), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .res_read  (res_read),
    .grant     (grant),
    .ex_valid  (ex_valid),
    .tp_vld    (tp_vld),
    .tp_tag    (tp_tag)
);

// File: tb/sp_unit_tb.sv
// Bench for sp_unit: an external add pipeline of LAT stages, a behavioural
// reference model advanced on each rising edge, and comparisons at each
// falling edge plus directed checks.
module sp_unit_tb;
    localparam int N   = 4;
    localparam int DW  = 16;
    localparam int LAT = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req_valid = '0;
    logic [N*DW-1:0] req_a = '0;
    logic [N*DW-1:0] req_b = '0;
    logic [N-1:0]    req_ready;
    logic [N-1:0]    done;
    logic [N*DW-1:0] res_data;
    logic [N-1:0]    res_read = '0;
    logic            ex_valid;
    logic [DW-1:0]   ex_a, ex_b, ex_res;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sp_unit #(.N(N), .DW(DW), .LAT(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_a(req_a),
        .req_b(req_b), .req_ready(req_ready), .done(done),
        .res_data(res_data), .res_read(res_read), .ex_valid(ex_valid),
        .ex_a(ex_a), .ex_b(ex_b), .ex_res(ex_res)
    );

    // Stand-in execution unit: add, LAT stages deep.
    logic [DW-1:0] xp [LAT];
    always @(posedge clk) begin
        xp[0] <= ex_a + ex_b;
        for (int k = 1; k < LAT; k++) xp[k] <= xp[k-1];
    end
    assign ex_res = xp[LAT-1];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model state.
    typedef struct { int tag; logic [DW-1:0] val; int due; } ent_t;
    ent_t q[$];
    logic [N-1:0]  m_busy, m_pend, m_full;
    logic [DW-1:0] m_a [N];
    logic [DW-1:0] m_b [N];
    logic [DW-1:0] m_res [N];
    int m_ptr;
    int cyc = 0;
    bit m_live = 1'b0;

    function automatic int pick();
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (m_ptr + k) % N;
            if (m_pend[idx]) return idx;
        end
        return -1;
    endfunction

    // Advance the model from the inputs driven before this edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_busy = '0; m_pend = '0; m_full = '0; m_ptr = N - 1;
            q.delete();
            m_live = 1'b0;
        end else begin
            logic [N-1:0] busy_pre;
            int g;
            busy_pre = m_busy;
            g = pick();
            if (g >= 0) begin
                ent_t e;
                e.tag = g; e.val = m_a[g] + m_b[g]; e.due = cyc + LAT;
                q.push_back(e);
                m_pend[g] = 1'b0;
                m_ptr = g;
            end
            for (int i = 0; i < N; i++) begin
                if (m_full[i] && res_read[i]) begin
                    m_full[i] = 1'b0;
                    m_busy[i] = 1'b0;
                end
            end
            while (q.size() > 0 && q[0].due == cyc) begin
                m_full[q[0].tag] = 1'b1;
                m_res[q[0].tag]  = q[0].val;
                void'(q.pop_front());
            end
            for (int i = 0; i < N; i++) begin
                if (!busy_pre[i] && req_valid[i]) begin
                    m_busy[i] = 1'b1;
                    m_pend[i] = 1'b1;
                    m_a[i] = req_a[i*DW +: DW];
                    m_b[i] = req_b[i*DW +: DW];
                end
            end
            m_live = 1'b1;
        end
    end

    // Compare every output with the model, away from the active edge.
    always @(negedge clk) begin
        if (m_live && !finished) begin
            int g;
            g = pick();
            for (int i = 0; i < N; i++) begin
                chk(req_ready[i] == !m_busy[i], "R2 ready", req_ready[i], !m_busy[i]);
                chk(done[i] == m_full[i], "R6 done", done[i], m_full[i]);
                if (m_full[i])
                    chk(res_data[i*DW +: DW] == m_res[i], "R6 result", res_data[i*DW +: DW], m_res[i]);
            end
            chk(ex_valid == (g >= 0), "R3 ex_valid", ex_valid, g >= 0);
            if (g >= 0) begin
                chk(ex_a == m_a[g] && ex_b == m_b[g], "R5 operands (R4 order)",
                    {ex_a, ex_b}, {m_a[g], m_b[g]});
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic put(input int s, input logic [DW-1:0] a, input logic [DW-1:0] b);
        req_valid[s] = 1'b1;
        req_a[s*DW +: DW] = a;
        req_b[s*DW +: DW] = b;
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (5) tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state.
        chk(req_ready == '1, "R1 ready", req_ready, '1);
        chk(done == '0, "R1 done", done, 0);
        chk(ex_valid == 1'b0, "R1 ex_valid", ex_valid, 0);

        // R6: single operation on slot 2, done exactly LAT+1 edges after accept.
        put(2, 16'h1234, 16'h0101);
        tick();
        req_valid = '0;
        chk(req_ready[2] == 1'b0, "R2 busy after accept", req_ready[2], 0);
        repeat (LAT) tick();
        chk(done[2] == 1'b0, "R6 not early", done[2], 0);
        tick();
        chk(done[2] == 1'b1, "R6 on time", done[2], 1);
        chk(res_data[2*DW +: DW] == 16'h1335, "R6 value", res_data[2*DW +: DW], 16'h1335);
        res_read[2] = 1'b1;
        tick();
        res_read = '0;
        chk(done[2] == 1'b0 && req_ready[2] == 1'b1, "R8 read frees", {done[2], req_ready[2]}, 2'b01);

        // R4: burst on all slots; last winner was 2, so slot 3 then 0 go first.
        for (int s = 0; s < N; s++) put(s, DW'(16'h0100 * (s + 1)), DW'(s + 7));
        tick();
        req_valid = '0;
        chk(ex_a == 16'h0400, "R4 first is slot 3", ex_a, 16'h0400);
        tick();
        chk(ex_a == 16'h0100, "R4 then slot 0", ex_a, 16'h0100);
        // R9: offer new operands to busy slot 1; they must be ignored.
        put(1, 16'hFFFF, 16'hFFFF);
        tick();
        req_valid = '0;
        repeat (LAT + N) tick();
        chk(done == '1, "R6 all done", done, '1);
        // R7: hold results for ten cycles without reading.
        repeat (10) tick();
        for (int s = 0; s < N; s++)
            chk(res_data[s*DW +: DW] == DW'(16'h0100 * (s + 1) + s + 7), "R7 held value",
                res_data[s*DW +: DW], DW'(16'h0100 * (s + 1) + s + 7));
        chk(res_data[DW +: DW] == 16'h0208, "R9 ignored offer", res_data[DW +: DW], 16'h0208);
        res_read = '1;
        tick();
        res_read = '0;
        chk(req_ready == '1, "R8 all freed", req_ready, '1);
        // R8: reads while nothing is held have no effect.
        res_read = '1;
        tick();
        res_read = '0;
        chk(req_ready == '1 && done == '0, "R8 idle read ignored", {req_ready, done}, {4'hF, 4'h0});

        // Random traffic, compared against the model each cycle.
        for (int c = 0; c < 3000; c++) begin
            req_valid = N'($urandom);
            for (int s = 0; s < N; s++) begin
                req_a[s*DW +: DW] = DW'($urandom);
                req_b[s*DW +: DW] = DW'($urandom);
            end
            res_read = N'($urandom) & N'($urandom);
            tick();
        end
        req_valid = '0;
        res_read = '0;
        repeat (3) tick();
        finish_run();
    end

endmodule